// File: doc/BRIEF.md
# Cache Maintenance Request Dispatcher

This block sits between the decode of cache-maintenance operations and the units that carry them out. Each cycle it may accept one request. The request carries an operation code, two flags from address translation (whether the lookup succeeded and whether the page is caching-inhibited), a small cache-touch operand, and the current configuration bits: data-cache enable, instruction-cache enable and bus broadcast enable. The block decides what the request actually does. The request can be silently retired as a no-op, raise a translation-miss trap, act on the local data or instruction L1, zero a line in memory only, or go out on the bus as a broadcast. A single request may take more than one of the last three actions.

The decision is registered into a response slot with a valid/ready handshake. Downstream units read the one-hot-style action flags and the normalised operation code from that slot. Address translation, the cache arrays and the bus protocol live elsewhere.

Top module: `cmo_dispatch`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1.
- R2: Operation codes on req_op are 0 alloc-zero, 1 load touch, 2 store touch, 3 zero-block, 4 data invalidate, 5 data flush, 6 data store-clean, 7 data lock-touch, 8 data unlock, 9 instruction touch, 10 instruction lock-touch, 11 instruction unlock, 12 instruction invalidate, and 13 to 15 reserved. rsp_op echoes the request code, except that code 6 is reported as 5 and has exactly the effects of code 5.
- R3: When req_xlate_ok is 0, codes 0, 1 and 2 retire as no-ops (rsp_nop=1). Every non-reserved code from 3 to 12 raises rsp_trap=1 instead.
- R4: A load or store touch (codes 1, 2) with req_inhibit=1 retires as a no-op.
- R5: An instruction touch (code 9) whose req_ct is zero retires as a no-op. With a nonzero req_ct and the instruction cache enabled, it sets rsp_ic_apply.
- R6: Touch, lock-touch and unlock codes (1, 2, 7, 8 against cfg_dc_en; 9, 10, 11 against cfg_ic_en) retire as no-ops while their cache is disabled. While it is enabled they set the matching apply flag and never rsp_bcast.
- R7: Zeroing codes 0 and 3 set rsp_dc_apply when cfg_dc_en=1. When cfg_dc_en=0 they set rsp_mem_zero instead. The two flags are never both 1.
- R8: Codes 4, 5 and 6 set rsp_dc_apply only when cfg_dc_en=1.
- R9: Code 12 sets rsp_ic_apply only when cfg_ic_en=1.
- R10: rsp_bcast is 1 only when cfg_bcast_en=1, and only for codes 0, 3, 4, 5, 6 and 12 that neither trap nor retire as no-ops.
- R11: A trapping response has rsp_dc_apply, rsp_ic_apply, rsp_mem_zero, rsp_bcast and rsp_nop all 0. rsp_nop is 1 exactly when no trap and no action flag is set.
- R12: req_ready equals !rsp_valid || rsp_ready. While rsp_valid=1 and rsp_ready=0, every response output holds its value.
- R13: Reserved codes 13 to 15 always retire as no-ops, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 4 | Operation code |
| req_xlate_ok | input | 1 | Address translation succeeded |
| req_inhibit | input | 1 | Target page is caching-inhibited |
| req_ct | input | CT_W (2) | Cache-touch operand |
| cfg_dc_en | input | 1 | Data cache enabled |
| cfg_ic_en | input | 1 | Instruction cache enabled |
| cfg_bcast_en | input | 1 | Bus broadcast of maintenance enabled |
| rsp_valid | output | 1 | Response slot full |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_op | output | 4 | Normalised operation code |
| rsp_trap | output | 1 | Translation-miss trap |
| rsp_dc_apply | output | 1 | Act on local data L1 |
| rsp_ic_apply | output | 1 | Act on local instruction L1 |
| rsp_mem_zero | output | 1 | Zero the line in memory only |
| rsp_bcast | output | 1 | Broadcast on the bus |
| rsp_nop | output | 1 | Retired with no effect |

## Verification
The hardest situation to reach is a held response: the slot must hold still while a different request waits at the input. The bench gets there by dropping rsp_ready before a flush is accepted. It then presents a zero-block request while the flush is stalled and checks that the slot keeps the flush for another cycle. After that it releases the consumer and checks that the waiting request follows in the next cycle. A second source of difficulty is the set of rules that overlap, such as a failed translation together with a reserved code or a lock operation. Table rows pin down each of these combinations one at a time.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ZALLOC   = 4'd0,
      OP_TOUCH_LD = 4'd1,
      OP_TOUCH_ST = 4'd2,
      OP_ZERO     = 4'd3,
      OP_DINV     = 4'd4,
      OP_DFLUSH   = 4'd5,
      OP_DCLEAN   = 4'd6,
      OP_DLOCK    = 4'd7,
      OP_DUNLOCK  = 4'd8,
      OP_ITOUCH   = 4'd9,
      OP_ILOCK    = 4'd10,
      OP_IUNLOCK  = 4'd11,
      OP_IINV     = 4'd12
   } op_e;

   // operation class flags, exactly one set per code
   typedef struct packed {
      logic zalloc;
      logic hint;
      logic zero;
      logic dmaint;
      logic dlock;
      logic itouch;
      logic ilock;
      logic iinv;
      logic rsvd;
   } opclass_t;

   typedef struct packed {
      logic [OP_W-1:0] op;
      logic            trap;
      logic            dc;
      logic            ic;
      logic            mem;
      logic            bc;
      logic            nop;
   } rsp_t;

endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
   import cmo_pkg::*;
#(
   parameter int OPW = OP_W
) (
   input  logic [OPW-1:0] op,
   output opclass_t       cls,
   output logic [OPW-1:0] eff_op
);

   if (OPW != OP_W) begin : g_bad_width
      $error("cmo_decode: OPW must match package OP_W");
   end

   always_comb begin
      cls = '0;
      case (op)
         OP_ZALLOC:                 cls.zalloc = 1'b1;
         OP_TOUCH_LD, OP_TOUCH_ST:  cls.hint   = 1'b1;
         OP_ZERO:                   cls.zero   = 1'b1;
         OP_DINV, OP_DFLUSH,
         OP_DCLEAN:                 cls.dmaint = 1'b1;
         OP_DLOCK, OP_DUNLOCK:      cls.dlock  = 1'b1;
         OP_ITOUCH:                 cls.itouch = 1'b1;
         OP_ILOCK, OP_IUNLOCK:      cls.ilock  = 1'b1;
         OP_IINV:                   cls.iinv   = 1'b1;
         default:                   cls.rsvd   = 1'b1;
      endcase
   end

   // store-clean is carried out as a flush
   assign eff_op = (op == OP_DCLEAN) ? OP_DFLUSH : op;

endmodule

// File: rtl/cmo_route.sv
module cmo_route
   import cmo_pkg::*;
#(
   parameter int CT_W = 2
) (
   input  opclass_t        cls,
   input  logic [OP_W-1:0] eff_op,
   input  logic            xlate_ok,
   input  logic            inhibit,
   input  logic [CT_W-1:0] ct,
   input  logic            dc_en,
   input  logic            ic_en,
   input  logic            bc_en,
   output rsp_t            rsp
);

   if (CT_W < 1) begin : g_bad_ct
      $error("cmo_route: CT_W must be at least 1");
   end

   logic ct_zero;
   if (CT_W == 1) begin : g_ct1
      assign ct_zero = ~ct[0];
   end else begin : g_ctn
      assign ct_zero = ~|ct;
   end

   logic exempt, trap, silent, act_dc, act_ic, act_mem, act_bc;

   always_comb begin
      exempt  = cls.zalloc | cls.hint | cls.rsvd;
      trap    = ~xlate_ok & ~exempt;
      silent  = cls.rsvd
              | (~xlate_ok & exempt)
              | (cls.hint & inhibit)
              | (cls.itouch & ct_zero);
      act_dc  = 1'b0;
      act_ic  = 1'b0;
      act_mem = 1'b0;
      act_bc  = 1'b0;
      if (!trap && !silent) begin
         act_dc  = dc_en & (cls.zalloc | cls.hint | cls.zero | cls.dmaint | cls.dlock);
         act_ic  = ic_en & (cls.itouch | cls.ilock | cls.iinv);
         act_mem = ~dc_en & (cls.zalloc | cls.zero);
         act_bc  = bc_en & (cls.zalloc | cls.zero | cls.dmaint | cls.iinv);
      end
      rsp.op   = eff_op;
      rsp.trap = trap;
      rsp.dc   = act_dc;
      rsp.ic   = act_ic;
      rsp.mem  = act_mem;
      rsp.bc   = act_bc;
      rsp.nop  = ~trap & ~(act_dc | act_ic | act_mem | act_bc);
   end

endmodule

// File: rtl/cmo_outreg.sv
module cmo_outreg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);

   if (DW < 1) begin : g_bad_dw
      $error("cmo_outreg: DW must be at least 1");
   end

   assign in_ready = ~out_valid | out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

   // R12: a stalled slot keeps its contents
   assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cmo_dispatch.sv
module cmo_dispatch
   import cmo_pkg::*;
#(
   parameter int CT_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [OP_W-1:0] req_op,
   input  logic            req_xlate_ok,
   input  logic            req_inhibit,
   input  logic [CT_W-1:0] req_ct,
   input  logic            cfg_dc_en,
   input  logic            cfg_ic_en,
   input  logic            cfg_bcast_en,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [OP_W-1:0] rsp_op,
   output logic            rsp_trap,
   output logic            rsp_dc_apply,
   output logic            rsp_ic_apply,
   output logic            rsp_mem_zero,
   output logic            rsp_bcast,
   output logic            rsp_nop
);

   localparam int RSP_W = $bits(rsp_t);

   opclass_t        cls;
   logic [OP_W-1:0] eff_op;
   rsp_t            nxt, cur;
   logic [RSP_W-1:0] cur_bits;

   cmo_decode #(.OPW(OP_W)) u_decode (
      .op     (req_op),
      .cls    (cls),
      .eff_op (eff_op)
   );

   cmo_route #(.CT_W(CT_W)) u_route (
      .cls      (cls),
      .eff_op   (eff_op),
      .xlate_ok (req_xlate_ok),
      .inhibit  (req_inhibit),
      .ct       (req_ct),
      .dc_en    (cfg_dc_en),
      .ic_en    (cfg_ic_en),
      .bc_en    (cfg_bcast_en),
      .rsp      (nxt)
   );

   cmo_outreg #(.DW(RSP_W)) u_outreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .in_data   (nxt),
      .out_valid (rsp_valid),
      .out_ready (rsp_ready),
      .out_data  (cur_bits)
   );

   assign cur          = rsp_t'(cur_bits);
   assign rsp_op       = cur.op;
   assign rsp_trap     = cur.trap;
   assign rsp_dc_apply = cur.dc;
   assign rsp_ic_apply = cur.ic;
   assign rsp_mem_zero = cur.mem;
   assign rsp_bcast    = cur.bc;
   assign rsp_nop      = cur.nop;

   // R2: store-clean never leaves the block under its own code
   assert_clean_mapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_op != OP_DCLEAN));

   // R7: memory-only zeroing excludes a local data action
   assert_zero_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_mem_zero) |-> !rsp_dc_apply);

   // R10: routing decision broadcasts only with the enable bit set
   assert_bcast_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && nxt.bc) |-> cfg_bcast_en);

   // R11: a trap carries no action and no no-op mark
   assert_trap_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap) |->
         !(rsp_dc_apply || rsp_ic_apply || rsp_mem_zero || rsp_bcast || rsp_nop));

   // R11: at most one of trap / no-op
   assert_outcome_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0({rsp_trap, rsp_nop}));

   // R12: ready follows slot state
   assert_ready_rule_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready == (!rsp_valid || rsp_ready));

endmodule

// File: tb/cmo_dispatch_tb.sv
`timescale 1ns/1ps
module cmo_dispatch_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [3:0] req_op = '0;
   logic       req_xlate_ok = 1'b1;
   logic       req_inhibit = 1'b0;
   logic [1:0] req_ct = 2'd2;
   logic       cfg_dc_en = 1'b1;
   logic       cfg_ic_en = 1'b1;
   logic       cfg_bcast_en = 1'b1;
   logic       rsp_valid;
   logic       rsp_ready = 1'b1;
   logic [3:0] rsp_op;
   logic       rsp_trap, rsp_dc_apply, rsp_ic_apply, rsp_mem_zero, rsp_bcast, rsp_nop;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   cmo_dispatch #(.CT_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_xlate_ok(req_xlate_ok), .req_inhibit(req_inhibit),
      .req_ct(req_ct), .cfg_dc_en(cfg_dc_en), .cfg_ic_en(cfg_ic_en),
      .cfg_bcast_en(cfg_bcast_en),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
      .rsp_trap(rsp_trap), .rsp_dc_apply(rsp_dc_apply), .rsp_ic_apply(rsp_ic_apply),
      .rsp_mem_zero(rsp_mem_zero), .rsp_bcast(rsp_bcast), .rsp_nop(rsp_nop)
   );

   // {req id, op, xlate_ok, inhibit, ct, {dc_en, ic_en, bcast_en},
   //  {trap, dc, ic, mem, bc, nop}, expected op}
   localparam int NV = 28;
   localparam logic [24:0] VEC [NV] = '{
      {4'd2,  4'd6,  1'b1, 1'b0, 2'd2, 3'b111, 6'b010010, 4'd5},  // R2 clean as flush
      {4'd2,  4'd5,  1'b1, 1'b0, 2'd2, 3'b111, 6'b010010, 4'd5},  // R2 flush
      {4'd3,  4'd0,  1'b0, 1'b0, 2'd2, 3'b111, 6'b000001, 4'd0},  // R3 alloc-zero miss
      {4'd3,  4'd1,  1'b0, 1'b0, 2'd2, 3'b111, 6'b000001, 4'd1},  // R3 load touch miss
      {4'd3,  4'd2,  1'b0, 1'b0, 2'd2, 3'b111, 6'b000001, 4'd2},  // R3 store touch miss
      {4'd3,  4'd4,  1'b0, 1'b0, 2'd2, 3'b111, 6'b100000, 4'd4},  // R3 invalidate traps
      {4'd3,  4'd9,  1'b0, 1'b0, 2'd2, 3'b111, 6'b100000, 4'd9},  // R3 itouch traps
      {4'd3,  4'd3,  1'b0, 1'b0, 2'd2, 3'b111, 6'b100000, 4'd3},  // R3 zero-block traps
      {4'd4,  4'd1,  1'b1, 1'b1, 2'd2, 3'b111, 6'b000001, 4'd1},  // R4 inhibited
      {4'd4,  4'd2,  1'b1, 1'b1, 2'd2, 3'b111, 6'b000001, 4'd2},  // R4 inhibited
      {4'd4,  4'd1,  1'b1, 1'b0, 2'd2, 3'b111, 6'b010000, 4'd1},  // R4 cacheable
      {4'd5,  4'd9,  1'b1, 1'b0, 2'd0, 3'b111, 6'b000001, 4'd9},  // R5 ct zero
      {4'd5,  4'd9,  1'b1, 1'b0, 2'd1, 3'b111, 6'b001000, 4'd9},  // R5 ct nonzero
      {4'd6,  4'd7,  1'b1, 1'b0, 2'd2, 3'b011, 6'b000001, 4'd7},  // R6 dlock, dc off
      {4'd6,  4'd10, 1'b1, 1'b0, 2'd2, 3'b101, 6'b000001, 4'd10}, // R6 ilock, ic off
      {4'd6,  4'd2,  1'b1, 1'b0, 2'd2, 3'b011, 6'b000001, 4'd2},  // R6 touch, dc off
      {4'd7,  4'd3,  1'b1, 1'b0, 2'd2, 3'b010, 6'b000100, 4'd3},  // R7 zero, dc off
      {4'd7,  4'd0,  1'b1, 1'b0, 2'd2, 3'b110, 6'b010000, 4'd0},  // R7 alloc, dc on
      {4'd7,  4'd0,  1'b1, 1'b0, 2'd2, 3'b011, 6'b000110, 4'd0},  // R7 alloc, dc off, bc
      {4'd8,  4'd4,  1'b1, 1'b0, 2'd2, 3'b011, 6'b000010, 4'd4},  // R8 inval, dc off
      {4'd8,  4'd5,  1'b1, 1'b0, 2'd2, 3'b010, 6'b000001, 4'd5},  // R8 flush, dc off, no bc
      {4'd9,  4'd12, 1'b1, 1'b0, 2'd2, 3'b101, 6'b000010, 4'd12}, // R9 iinv, ic off
      {4'd9,  4'd12, 1'b1, 1'b0, 2'd2, 3'b110, 6'b001000, 4'd12}, // R9 iinv, ic on
      {4'd10, 4'd4,  1'b1, 1'b0, 2'd2, 3'b110, 6'b010000, 4'd4},  // R10 no bcast enable
      {4'd10, 4'd11, 1'b1, 1'b0, 2'd2, 3'b111, 6'b001000, 4'd11}, // R10 unlock never bc
      {4'd13, 4'd14, 1'b0, 1'b0, 2'd2, 3'b111, 6'b000001, 4'd14}, // R13 reserved miss
      {4'd13, 4'd13, 1'b1, 1'b0, 2'd2, 3'b111, 6'b000001, 4'd13}, // R13 reserved
      {4'd11, 4'd8,  1'b0, 1'b0, 2'd2, 3'b111, 6'b100000, 4'd8}   // R11 unlock traps
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] flags();
      return {rsp_trap, rsp_dc_apply, rsp_ic_apply, rsp_mem_zero, rsp_bcast, rsp_nop};
   endfunction

   initial begin
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      check("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req_op       = VEC[i][20:17];
         req_xlate_ok = VEC[i][16];
         req_inhibit  = VEC[i][15];
         req_ct       = VEC[i][14:13];
         {cfg_dc_en, cfg_ic_en, cfg_bcast_en} = VEC[i][12:10];
         req_valid    = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check($sformatf("R%0d row %0d valid", VEC[i][24:21], i), {31'd0, rsp_valid}, 32'd1);
         check($sformatf("R%0d row %0d flags", VEC[i][24:21], i), {26'd0, flags()}, {26'd0, VEC[i][9:4]});
         check($sformatf("R%0d row %0d op", VEC[i][24:21], i), {28'd0, rsp_op}, {28'd0, VEC[i][3:0]});
      end

      // R12: stall holds a flush while a zero-block waits
      @(negedge clk);
      rsp_ready = 1'b0;
      {cfg_dc_en, cfg_ic_en, cfg_bcast_en} = 3'b111;
      req_xlate_ok = 1'b1; req_inhibit = 1'b0; req_ct = 2'd2;
      req_op = 4'd5; req_valid = 1'b1;
      @(negedge clk);
      check("R12 slot full", {31'd0, rsp_valid}, 32'd1);
      check("R12 ready low when stalled", {31'd0, req_ready}, 32'd0);
      req_op = 4'd3;
      @(negedge clk);
      check("R12 held op", {28'd0, rsp_op}, 32'd5);
      check("R12 held flags", {26'd0, flags()}, {26'd0, 6'b010010});
      check("R12 ready while stalled", {31'd0, req_ready}, 32'd0);
      rsp_ready = 1'b1;
      #1;
      check("R12 ready follows consumer", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check("R12 next request follows", {28'd0, rsp_op}, 32'd3);
      check("R12 next flags", {26'd0, flags()}, {26'd0, 6'b010010});
      @(negedge clk);
      check("R12 slot drains", {31'd0, rsp_valid}, 32'd0);

      // R1: reset in mid-stream clears the slot
      req_op = 4'd4; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 slot cleared by reset", {31'd0, rsp_valid}, 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule